// File: doc/BRIEF.md
# Circular trace memory address generator

This block produces the write addresses for a trace buffer that sits in system memory. Software programs a lower and an upper byte bound through a small register port. A write pointer starts at the lower bound and moves up by one word each time the trace FIFO hands over a word. The block raises a write strobe in the same cycle as the word, with the pointer value as the address. An external bus master performs the memory write; this block only supplies the address, the valid strobe and a stop flag.

Two modes decide what happens at the upper bound. In wrap mode the pointer goes back to the lower bound and keeps writing over older data. In single-pass mode the block enters a halted state and stops accepting words. Both cases raise a memory-full event. A word that arrives while the input FIFO signals full is dropped and raises an overflow event. Each event sets a sticky raw bit. A raw bit drives the interrupt line only while its enable bit is set. Software clears a raw bit by writing one to it. A control strobe loads the lower bound back into the pointer and leaves the halted state.

The pointer sequencer has two states. In `ST_RUN` words are accepted. `ST_HALT` is entered by the transition *last-word-single-pass*: a word is accepted at the final slot while single-pass mode is selected. `ST_HALT` returns to `ST_RUN` by the transition *reload*, which is the control strobe. A reload in `ST_RUN` stays in `ST_RUN` and only moves the pointer.

Top module: `trace_addr_gen`

## Requirements
- R1: After reset the registers read as follows: lower bound 0, upper bound 0xFFFFFFFF, pointer 0, wrap mode 1, interrupt enables 0, raw status 0. The outputs `irq`, `wr_valid` and `wr_stop` are all 0.
- R2: A word is accepted when `word_valid` is 1, `fifo_full` is 0 and the block is not halted. In that cycle `wr_valid` is 1 and `wr_addr` equals the pointer. In the next cycle the pointer is 4 higher, provided pointer+4 does not exceed the upper bound. `wr_addr` always shows the pointer.
- R3: The test "pointer+4 exceeds the upper bound" is an unsigned compare one bit wider than the address. When a word is accepted and this test is true in wrap mode, the pointer becomes the lower bound in the next cycle and raw bit 1 (memory full) is set.
- R4: When a word is accepted and the same test is true in single-pass mode, the block halts. While halted, `wr_stop` is 1, the pointer holds its last written address, `wr_valid` stays 0 and raw bit 1 is set.
- R5: Writing control (index 3) with bit 0 set copies the lower bound into the pointer and leaves the halted state. This reload takes priority over an advance in the same cycle. Bit 0 reads back as 0.
- R6: When `word_valid` and `fifo_full` are both 1, the word is dropped. `wr_valid` is 0, the pointer is unchanged and raw bit 0 (FIFO overflow) is set.
- R7: `irq` is 1 exactly when a raw bit and its enable bit (index 4, bit 0 overflow, bit 1 memory full) are both 1.
- R8: Writing 1 to a bit of the clear register (index 6) clears that raw bit. A clear takes priority over a set in the same cycle.
- R9: Register map by word index. Index 0 is the lower bound. Index 1 is the upper bound. Index 2 is the pointer. Index 3 is control: bit 0 is the reload strobe, bit 1 selects wrap mode, bit 2 reads as the halted flag. Index 4 holds the enables. Index 5 holds the raw status. Unused bits and indices 6 and 7 read as 0.
- R10: Writes to index 2 and index 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_idx` (combinational) |
| word_valid | input | 1 | A trace word is offered this cycle |
| fifo_full | input | 1 | The input FIFO is full; the offered word is dropped |
| wr_addr | output | 32 | Current write pointer, the memory address for the word |
| wr_valid | output | 1 | The offered word is accepted and is written at `wr_addr` |
| wr_stop | output | 1 | The block is halted at the end of a single pass |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives a behavioural model alongside the block and compares every output on every clock. It targets the corners where a careless design goes wrong. At the final slot, an off-by-one compare would write one word past the upper bound or wrap one word early. With an upper bound of 0xFFFFFFFF, a compare only 32 bits wide would overflow and never wrap. If a clear and a set land in the same cycle and the set wins, the interrupt stays stuck after software clears it. The bench also checks that a dropped word leaves the pointer where it was, and that a reload both ends a halted single pass and takes priority over an advance in the same cycle.

// File: rtl/trace_addr_pkg.sv
package trace_addr_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ptr_state_e;

    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_LO    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_HI    = 3'd1;
    localparam logic [IDX_W-1:0] IDX_PTR   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_IEN   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_IRAW  = 3'd5;
    localparam logic [IDX_W-1:0] IDX_ICLR  = 3'd6;

    localparam int NUM_EVT  = 2;
    localparam int EVT_OVF  = 0;
    localparam int EVT_FULL = 1;

    localparam int CTRL_RELOAD = 0;
    localparam int CTRL_WRAP   = 1;
    localparam int CTRL_HALTED = 2;

endpackage

// File: rtl/trace_cfg_regs.sv
module trace_cfg_regs
    import trace_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [ADDR_W-1:0]    reg_wdata,
    input  logic [ADDR_W-1:0]    ptr,
    input  logic                 halted,
    input  logic [NUM_EVT-1:0]   evt_raw,
    output logic [ADDR_W-1:0]    lo_q,
    output logic [ADDR_W-1:0]    hi_q,
    output logic                 wrap_q,
    output logic [NUM_EVT-1:0]   evt_en_q,
    output logic                 reload,
    output logic [NUM_EVT-1:0]   evt_clr,
    output logic [ADDR_W-1:0]    reg_rdata
);

    logic wr_lo, wr_hi, wr_ctrl, wr_ien, wr_iclr;

    always_comb begin
        wr_lo   = reg_wr && (reg_idx == IDX_LO);
        wr_hi   = reg_wr && (reg_idx == IDX_HI);
        wr_ctrl = reg_wr && (reg_idx == IDX_CTRL);
        wr_ien  = reg_wr && (reg_idx == IDX_IEN);
        wr_iclr = reg_wr && (reg_idx == IDX_ICLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '1;
            wrap_q   <= 1'b1;
            evt_en_q <= '0;
        end else begin
            if (wr_lo)   lo_q     <= reg_wdata;
            if (wr_hi)   hi_q     <= reg_wdata;
            if (wr_ctrl) wrap_q   <= reg_wdata[CTRL_WRAP];
            if (wr_ien)  evt_en_q <= reg_wdata[NUM_EVT-1:0];
        end
    end

    always_comb begin
        reload  = wr_ctrl && reg_wdata[CTRL_RELOAD];
        evt_clr = wr_iclr ? reg_wdata[NUM_EVT-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_LO:   reg_rdata = lo_q;
            IDX_HI:   reg_rdata = hi_q;
            IDX_PTR:  reg_rdata = ptr;
            IDX_CTRL: begin
                reg_rdata[CTRL_WRAP]   = wrap_q;
                reg_rdata[CTRL_HALTED] = halted;
            end
            IDX_IEN:  reg_rdata[NUM_EVT-1:0] = evt_en_q;
            IDX_IRAW: reg_rdata[NUM_EVT-1:0] = evt_raw;
            default:  reg_rdata = '0;
        endcase
    end

    // R5: the reload strobe exists only in the cycle of a control write
    a_r5_reload_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> (reg_wr && reg_idx == IDX_CTRL));

    // R9: the wrap bit keeps its value unless control is written
    a_r9_wrap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_idx == IDX_CTRL) |=> $stable(wrap_q));

endmodule

// File: rtl/trace_ptr_fsm.sv
module trace_ptr_fsm
    import trace_addr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              wrap,
    input  logic              reload,
    input  logic              word_valid,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] ptr,
    output logic              halted,
    output logic              wr_valid,
    output logic              full_evt,
    output logic              ovf_evt
);

    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] STEP = SUM_W'(WORD_BYTES);

    ptr_state_e state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [SUM_W-1:0]  ptr_plus;
    logic              last_slot;
    logic              accept;

    always_comb begin
        ptr_plus  = {1'b0, ptr_q} + STEP;
        last_slot = ptr_plus > {1'b0, hi};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // next state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_RUN: begin
                if (reload) begin
                    ptr_d = lo;
                end else if (accept) begin
                    if (!last_slot) begin
                        ptr_d = ptr_plus[ADDR_W-1:0];
                    end else if (wrap) begin
                        ptr_d = lo;
                    end else begin
                        state_d = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (reload) begin
                    ptr_d   = lo;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_RUN:  accept = word_valid && !fifo_full;
            ST_HALT: halted = 1'b1;
            default: accept = 1'b0;
        endcase
        wr_valid = accept;
        full_evt = accept && last_slot;
        ovf_evt  = word_valid && fifo_full;
        ptr      = ptr_q;
    end

    // R2: a plain accepted word moves the pointer by one word
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last_slot && !reload) |=> (ptr_q == $past(ptr_q) + ADDR_W'(WORD_BYTES)));

    // R3: wrap at the last slot lands on the lower bound
    a_r3_wrap_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_slot && wrap && !reload) |=> (ptr_q == $past(lo)));

    // R4: a halted block holds its pointer and issues no write
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !reload) |=> ($stable(ptr_q) && !wr_valid));

    // R6: a dropped word leaves the pointer unchanged
    a_r6_drop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && fifo_full && !reload) |=> $stable(ptr_q));

    // R5: reload leaves the halted state with the lower bound in the pointer
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (ptr_q == $past(lo) && state_q == ST_RUN));

endmodule

// File: rtl/trace_evt_irq.sv
module trace_evt_irq #(
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] evt_clr,
    input  logic [NUM_EVT-1:0] evt_en,
    output logic [NUM_EVT-1:0] evt_raw,
    output logic               irq
);

    logic [NUM_EVT-1:0] raw_q;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          raw_q[i] <= 1'b0;
            else if (evt_clr[i]) raw_q[i] <= 1'b0;
            else if (evt_set[i]) raw_q[i] <= 1'b1;
        end

        // R8: a clear wins over a set in the same cycle
        a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt_clr[i] |=> !raw_q[i]);

        // R3: an uncleared event is recorded
        a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_set[i] && !evt_clr[i]) |=> raw_q[i]);
    end

    always_comb begin
        evt_raw = raw_q;
        irq     = |(raw_q & evt_en);
    end

endmodule

// File: rtl/trace_addr_gen.sv
module trace_addr_gen
    import trace_addr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              word_valid,
    input  logic              fifo_full,
    output logic [31:0]       wr_addr,
    output logic              wr_valid,
    output logic              wr_stop,
    output logic              irq
);

    logic [ADDR_W-1:0]  lo_q, hi_q, ptr;
    logic               wrap_q, reload, halted, full_evt, ovf_evt;
    logic [NUM_EVT-1:0] evt_en_q, evt_clr, evt_raw, evt_set;

    always_comb begin
        evt_set           = '0;
        evt_set[EVT_OVF]  = ovf_evt;
        evt_set[EVT_FULL] = full_evt;
    end

    trace_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .ptr       (ptr),
        .halted    (halted),
        .evt_raw   (evt_raw),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .wrap_q    (wrap_q),
        .evt_en_q  (evt_en_q),
        .reload    (reload),
        .evt_clr   (evt_clr),
        .reg_rdata (reg_rdata)
    );

    trace_ptr_fsm #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo         (lo_q),
        .hi         (hi_q),
        .wrap       (wrap_q),
        .reload     (reload),
        .word_valid (word_valid),
        .fifo_full  (fifo_full),
        .ptr        (ptr),
        .halted     (halted),
        .wr_valid   (wr_valid),
        .full_evt   (full_evt),
        .ovf_evt    (ovf_evt)
    );

    trace_evt_irq #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .evt_clr (evt_clr),
        .evt_en  (evt_en_q),
        .evt_raw (evt_raw),
        .irq     (irq)
    );

    always_comb begin
        wr_addr = ptr;
        wr_stop = halted;
    end

    // R4: the stop flag and a write strobe never coincide
    a_r4_stop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |-> !wr_valid);

    // R7: an interrupt needs an enabled, recorded event
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((evt_raw & evt_en_q) != '0));

endmodule

// File: tb/tb_trace_addr_gen.sv
module tb_trace_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        word_valid = 1'b0;
    logic        fifo_full = 1'b0;
    logic [31:0] wr_addr;
    logic        wr_valid;
    logic        wr_stop;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [31:0] m_lo, m_hi, m_ptr;
    logic        m_wrap, m_halt;
    logic [1:0]  m_en, m_raw;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_valid(word_valid),
        .fifo_full(fifo_full), .wr_addr(wr_addr), .wr_valid(wr_valid),
        .wr_stop(wr_stop), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] idx);
        case (idx)
            3'd0: return m_lo;
            3'd1: return m_hi;
            3'd2: return m_ptr;
            3'd3: return {29'd0, m_halt, m_wrap, 1'b0};
            3'd4: return {30'd0, m_en};
            3'd5: return {30'd0, m_raw};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_lo = 32'd0; m_hi = 32'hFFFF_FFFF; m_ptr = 32'd0;
        m_wrap = 1'b1; m_halt = 1'b0; m_en = 2'b00; m_raw = 2'b00;
    endtask

    // one clock: drive at negedge, compare outputs, then advance model after posedge
    task automatic step(input string tag, input logic wr, input logic [2:0] idx,
                        input logic [31:0] wd, input logic wv, input logic ff);
        logic        acc, last, rel, setf, seto;
        logic [1:0]  clr;
        logic [32:0] nxt;
        reg_wr = wr; reg_idx = idx; reg_wdata = wd; word_valid = wv; fifo_full = ff;
        #1;
        acc = wv && !ff && !m_halt;
        chk(tag, "wr_valid", {31'd0, wr_valid}, {31'd0, acc});
        chk(tag, "wr_addr", wr_addr, m_ptr);
        chk(tag, "wr_stop", {31'd0, wr_stop}, {31'd0, m_halt});
        chk(tag, "irq", {31'd0, irq}, {31'd0, |(m_raw & m_en)});
        chk(tag, "reg_rdata", reg_rdata, model_read(idx));
        @(posedge clk);
        nxt  = {1'b0, m_ptr} + 33'd4;
        last = nxt > {1'b0, m_hi};
        rel  = wr && idx == 3'd3 && wd[0];
        clr  = (wr && idx == 3'd6) ? wd[1:0] : 2'b00;
        seto = wv && ff;
        setf = acc && last;
        if (rel) begin
            m_ptr = m_lo; m_halt = 1'b0;
        end else if (acc) begin
            if (!last)       m_ptr = nxt[31:0];
            else if (m_wrap) m_ptr = m_lo;
            else             m_halt = 1'b1;
        end
        if (clr[0]) m_raw[0] = 1'b0; else if (seto) m_raw[0] = 1'b1;
        if (clr[1]) m_raw[1] = 1'b0; else if (setf) m_raw[1] = 1'b1;
        if (wr) begin
            case (idx)
                3'd0: m_lo = wd;
                3'd1: m_hi = wd;
                3'd3: m_wrap = wd[1];
                3'd4: m_en = wd[1:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [2:0] idx);
        step(tag, 1'b0, idx, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [2:0] idx, input logic [31:0] d);
        step(tag, 1'b1, idx, d, 1'b0, 1'b0);
    endtask

    task automatic push(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 3'd2, 32'd0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        #3;
        chk("R1", "irq at reset", {31'd0, irq}, 32'd0);
        chk("R1", "wr_stop at reset", {31'd0, wr_stop}, 32'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R9: reset values through every index
        for (int i = 0; i < 8; i++) rd("R1_R9", 3'(i));
        // R10: writes to the pointer and raw indices are ignored
        wr("R10", 3'd2, 32'h1234_5678);
        wr("R10", 3'd5, 32'h3);
        rd("R10", 3'd2);
        rd("R10", 3'd5);
        // R5: program a four-word window and reload
        wr("R9", 3'd0, 32'h0000_0100);
        wr("R9", 3'd1, 32'h0000_010F);
        wr("R5", 3'd3, 32'h3);
        rd("R5", 3'd3);
        // R2 and R3: fill and wrap in wrap mode
        push("R2", 4);
        push("R3", 2);
        rd("R3", 3'd5);
        // R7: enable both events, memory full is pending
        wr("R7", 3'd4, 32'h3);
        rd("R7", 3'd4);
        // R6: dropped word, pointer unchanged
        step("R6", 1'b0, 3'd2, 32'd0, 1'b1, 1'b1);
        rd("R6", 3'd5);
        // R8: clear both
        wr("R8", 3'd6, 32'h3);
        rd("R8", 3'd5);
        // R8: clear overflow while a new overflow arrives, clear wins
        step("R8", 1'b1, 3'd6, 32'h1, 1'b1, 1'b1);
        rd("R8", 3'd5);
        // R7: only overflow enabled, memory-full raised
        wr("R7", 3'd4, 32'h1);
        push("R7", 4);
        rd("R7", 3'd5);
        wr("R8", 3'd6, 32'h2);
        // R5: reload takes priority over an accepted word
        push("R5", 1);
        step("R5", 1'b1, 3'd3, 32'h3, 1'b1, 1'b0);
        // R4: single pass ends in halt
        wr("R4", 3'd3, 32'h1);
        push("R4", 4);
        push("R4", 3);
        rd("R4", 3'd3);
        rd("R4", 3'd2);
        step("R4", 1'b0, 3'd5, 32'd0, 1'b1, 1'b1);
        // R5: reload leaves halt
        wr("R5", 3'd3, 32'h1);
        push("R5", 2);
        // R3: upper bound at the top of the address space
        wr("R3", 3'd0, 32'hFFFF_FFF8);
        wr("R3", 3'd1, 32'hFFFF_FFFF);
        wr("R3", 3'd3, 32'h3);
        wr("R8", 3'd6, 32'h3);
        push("R3", 5);
        rd("R3", 3'd5);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule